// File: doc/BRIEF.md
# Audio Receive FIFO with Interrupts

This block sits between a PCM decimator and a host processor. Each cycle the decimator may offer one left sample and one right sample, each 24 bits wide and right-justified. A channel mode decides what is kept: nothing, only the left input, only the right input, or both. A swap bit can exchange the two inputs first. Each kept sample is cut to the programmed word length and widened to 32 bits with zeros or with copies of its top bit. It is then stored in a 256-location ring that holds at most 255 entries.

The host uses a small register port with a write strobe, a read strobe, a 3-bit word address and 32-bit data. Reading the pop word takes out the oldest entry. Reading the peek word returns that entry and leaves it in place. A status word reports the fill count and both pointers. Four sticky request bits record the events: fill above level, not empty, overflow and underflow. Software can clear them by writing ones, force them with a set word, and gate them with a mask. `trigReq` asserts while the fill count is strictly greater than the programmed level. `irq` is the OR of the masked requests.

Top module: `pcm_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty, both pointers are 0, the configuration, request and mask words read 0, and `trigReq` and `irq` are low.
- R2: The configuration word (address 0) reads back as written. Its fields are:
  - bits [1:0], channel mode: 0 = disabled, 1 = left only, 2 = right only, 3 = both.
  - bit 2: swap.
  - bits [5:4]: word length.
  - bit 6: sign fill.
  - bits [15:8]: trigger level.
  - bit 16: clear.
  - bit 17: freeze.
  
  When `sampleValid` is high in a single-channel mode, exactly one entry is written. When swap is 1 the two inputs are exchanged before selection. Mode 0 writes nothing.
- R3: In mode 3 the (swapped) left sample is stored first and the right sample second, as two consecutive entries. The pair is written only when the fill count is at most 253. Otherwise nothing is written.
- R4: Word length code 0, 1, 2 or 3 keeps the low 16, 18, 20 or 24 input bits. The bits above are filled with zeros when sign fill is 0, and with the kept most significant bit when it is 1.
- R5: Reading address 2 (pop) returns the oldest entry and advances the read pointer. Reading address 3 (peek) returns the same entry without removing it. A pop on an empty FIFO returns 0 and leaves the read pointer unchanged.
- R6: The status word (address 1) holds the fill count in bits [7:0], the read pointer in [15:8] and the write pointer in [23:16]. The FIFO never holds more than 255 entries.
- R7: `trigReq` is high exactly while the fill count is strictly greater than the trigger level. The same condition sets request bit 16 one cycle later.
- R8: While clear is 1, both pointers are forced to 0. The FIFO stays empty and incoming samples are dropped.
- R9: While freeze is 1, incoming samples are dropped, the write pointer holds, and no overflow is recorded.
- R10: Request bit 21 is set when an accepted sample finds too little room. Request bit 22 is set by a pop on an empty FIFO. Request bit 18 is set while the FIFO is not empty.
- R11: The request word (address 4) is sticky. Writing ones to it clears bits, writing ones to address 5 sets bits, and a hardware set in the same cycle as a clear wins. Address 5 reads 0.
- R12: The mask word (address 6) keeps bits 16, 18, 21 and 22. Address 7 returns request AND mask. `irq` is high when that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A sample pair is offered this cycle |
| sampleLeft | input | 24 | Left PCM sample, right-justified |
| sampleRight | input | 24 | Right PCM sample, right-justified |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops at address 2) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| trigReq | output | 1 | Fill count above trigger level |
| irq | output | 1 | Any masked request active |

## Verification
The collisions that matter are a decimator write landing in the same cycle as a host pop, and a hardware event landing in the same cycle as a software write-one-to-clear of the same request bit. The bench drives random sample traffic while it pops and writes to the request word. It also deliberately clears the not-empty and trigger bits while those conditions hold. The behavioural model predicts every cycle that the room check uses the pre-pop count and that the set wins. These predictions are compared with the read data, `trigReq` and `irq` on every clock.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int WORD_W   = 32;

  // request bit positions in the 32-bit request/mask view
  localparam int BIT_TRIG  = 16;
  localparam int BIT_NEMPT = 18;
  localparam int BIT_OVF   = 21;
  localparam int BIT_UND   = 22;

  typedef enum logic [2:0] {
    SEL_CFG    = 3'd0,
    SEL_STAT   = 3'd1,
    SEL_POP    = 3'd2,
    SEL_PEEK   = 3'd3,
    SEL_REQ    = 3'd4,
    SEL_SET    = 3'd5,
    SEL_MASK   = 3'd6,
    SEL_MASKED = 3'd7
  } regSel_t;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_LEFT  = 2'd1,
    CH_RIGHT = 2'd2,
    CH_BOTH  = 2'd3
  } chanMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clr;
    logic pushOne;
    logic pushTwo;
    logic pushRight;
    logic pop;
  } fifoStrobe_t;

  function automatic logic [WORD_W-1:0] extendSample(
      input logic [SAMPLE_W-1:0] s, input logic [1:0] wl, input logic sgn);
    logic [WORD_W-1:0] wide;
    logic [WORD_W-1:0] r;
    int bits;
    wide = {{(WORD_W-SAMPLE_W){1'b0}}, s};
    bits = (wl == 2'd3) ? 24 : 16 + 2 * int'(wl);
    for (int i = 0; i < WORD_W; i++)
      r[i] = (i < bits) ? wide[i] : (sgn & wide[bits-1]);
    return r;
  endfunction

  // 4-bit request vector {und, ovf, nempt, trig} <-> 32-bit view
  function automatic logic [3:0] unpackReq(input logic [WORD_W-1:0] w);
    return {w[BIT_UND], w[BIT_OVF], w[BIT_NEMPT], w[BIT_TRIG]};
  endfunction

  function automatic logic [WORD_W-1:0] packReq(input logic [3:0] v);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_TRIG]  = v[0];
    w[BIT_NEMPT] = v[1];
    w[BIT_OVF]   = v[2];
    w[BIT_UND]   = v[3];
    return w;
  endfunction
endpackage

// File: rtl/pcm_rx_datapath.sv
module pcm_rx_datapath
  import pcm_rx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                swapLr,
  input  logic [1:0]          wordLen,
  input  logic                signFill,
  output logic [ADDR_W-1:0]   used,
  output logic [ADDR_W-1:0]   rdPtr,
  output logic [ADDR_W-1:0]   wrPtr,
  output logic [WORD_W-1:0]   headData
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] PTR_ONE   = 1;
  localparam logic [ADDR_W-1:0] PTR_TWO   = 2;
  localparam logic [ADDR_W-1:0] FULL_LVL  = '1;
  localparam logic [ADDR_W-1:0] ROOM2_LVL = FULL_LVL - PTR_ONE;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] firstIn, secondIn;
  logic [WORD_W-1:0] firstWord, secondWord;

  always_comb begin
    firstIn  = swapLr ? sampleRight : sampleLeft;
    secondIn = swapLr ? sampleLeft  : sampleRight;
    if (strobe.pushOne && strobe.pushRight) firstIn = secondIn;
    firstWord  = extendSample(firstIn, wordLen, signFill);
    secondWord = extendSample(secondIn, wordLen, signFill);
  end

  assign used     = wrPtr - rdPtr;
  assign headData = (used == '0) ? '0 : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.pushOne)      wrPtr <= wrPtr + PTR_ONE;
      else if (strobe.pushTwo) wrPtr <= wrPtr + PTR_TWO;
      if (strobe.pop && used != '0) rdPtr <= rdPtr + PTR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushOne || strobe.pushTwo) mem[wrPtr] <= firstWord;
    if (strobe.pushTwo) mem[wrPtr + PTR_ONE] <= secondWord;
  end

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (used == '0));
  p_pair_room_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushTwo |-> (used < ROOM2_LVL));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushOne |-> (used != FULL_LVL));
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pushOne && !strobe.pushTwo && !strobe.clr) |=> $stable(wrPtr));
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && used == '0 && !strobe.clr) |=> $stable(rdPtr));
endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
  import pcm_rx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] used,
  input  logic [ADDR_W-1:0] rdPtr,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic [WORD_W-1:0] headData,
  output fifoStrobe_t       strobe,
  output logic              swapLr,
  output logic [1:0]        wordLen,
  output logic              signFill,
  output logic              trigReq,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] FULL_LVL  = '1;
  localparam logic [ADDR_W-1:0] ROOM2_LVL = FULL_LVL - 1;

  logic [WORD_W-1:0] cfgReg;
  logic [3:0] reqBits, maskBits, hwEvt, clrVec, setVec;
  chanMode_t chanMode;
  logic [ADDR_W-1:0] trigLevel;
  logic cfgClear, cfgFreeze, acceptIn, roomOk, needPair, popReq;
  regSel_t sel;

  assign sel       = regSel_t'(regAddr);
  assign chanMode  = chanMode_t'(cfgReg[1:0]);
  assign swapLr    = cfgReg[2];
  assign wordLen   = cfgReg[5:4];
  assign signFill  = cfgReg[6];
  assign trigLevel = cfgReg[8 +: ADDR_W];
  assign cfgClear  = cfgReg[16];
  assign cfgFreeze = cfgReg[17];

  always_comb begin
    needPair = (chanMode == CH_BOTH);
    acceptIn = sampleValid && chanMode != CH_OFF && !cfgFreeze && !cfgClear;
    roomOk   = needPair ? (used < ROOM2_LVL) : (used != FULL_LVL);
    popReq   = regRdEn && sel == SEL_POP && !cfgClear;
    strobe.clr       = cfgClear;
    strobe.pushOne   = acceptIn && !needPair && roomOk;
    strobe.pushTwo   = acceptIn && needPair && roomOk;
    strobe.pushRight = (chanMode == CH_RIGHT);
    strobe.pop       = popReq;
    hwEvt  = {popReq && used == '0, acceptIn && !roomOk, used != '0, used > trigLevel};
    clrVec = (regWrEn && sel == SEL_REQ) ? unpackReq(regWrData) : 4'b0;
    setVec = (regWrEn && sel == SEL_SET) ? unpackReq(regWrData) : 4'b0;
  end

  assign trigReq = used > trigLevel;
  assign irq     = |(reqBits & maskBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      reqBits  <= '0;
      maskBits <= '0;
    end else begin
      if (regWrEn && sel == SEL_CFG)  cfgReg   <= regWrData;
      if (regWrEn && sel == SEL_MASK) maskBits <= unpackReq(regWrData);
      reqBits <= (reqBits & ~clrVec) | hwEvt | setVec;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (sel)
      SEL_CFG:    regRdData = cfgReg;
      SEL_STAT: begin
        regRdData[0  +: ADDR_W] = used;
        regRdData[8  +: ADDR_W] = rdPtr;
        regRdData[16 +: ADDR_W] = wrPtr;
      end
      SEL_POP, SEL_PEEK: regRdData = headData;
      SEL_REQ:    regRdData = packReq(reqBits);
      SEL_SET:    regRdData = '0;
      SEL_MASK:   regRdData = packReq(maskBits);
      SEL_MASKED: regRdData = packReq(reqBits & maskBits);
    endcase
  end

  p_trig_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (used > trigLevel) |=> reqBits[0]);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && sel == SEL_REQ && regWrData[BIT_NEMPT] && used != '0) |=> reqBits[1]);
  p_underflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && sel == SEL_POP && !cfgClear && used == '0) |=> reqBits[3]);
  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == 4'b0) |-> !irq);
endmodule

// File: rtl/pcm_rx_fifo.sv
module pcm_rx_fifo
  import pcm_rx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [2:0]          regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  output logic                trigReq,
  output logic                irq
);
  fifoStrobe_t strobe;
  logic [ADDR_W-1:0] used, rdPtr, wrPtr;
  logic [WORD_W-1:0] headData;
  logic swapLr, signFill;
  logic [1:0] wordLen;

  pcm_rx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .used(used), .rdPtr(rdPtr), .wrPtr(wrPtr), .headData(headData),
    .strobe(strobe), .swapLr(swapLr), .wordLen(wordLen), .signFill(signFill),
    .trigReq(trigReq), .irq(irq)
  );

  pcm_rx_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .swapLr(swapLr), .wordLen(wordLen), .signFill(signFill),
    .used(used), .rdPtr(rdPtr), .wrPtr(wrPtr), .headData(headData)
  );
endmodule

// File: tb/pcm_rx_fifo_bench.sv
module pcm_rx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VM = 32'h0065_0000;

  logic clk = 0, rstN = 0;
  logic sampleValid = 0;
  logic [23:0] sampleLeft = 0, sampleRight = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0] regAddr = 3'd1;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic trigReq, irq;

  pcm_rx_fifo u_pcm_rx_fifo (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .trigReq(trigReq), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] lastRd;

  // behavioural reference state
  logic [31:0] mq[$];
  int mRd = 0, mWr = 0;
  logic [31:0] mReq = 0, mMask = 0, mCfg = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mExt(input logic [23:0] s, input int wl, input bit sg);
    int bits;
    logic [31:0] m, v;
    bits = (wl == 3) ? 24 : 16 + 2 * wl;
    m = (32'd1 << bits) - 1;
    v = {8'd0, s} & m;
    if (sg && v[bits-1]) v = v | ~m;
    return v;
  endfunction

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mCfg;
      3'd1: return {8'd0, 8'(mWr), 8'(mRd), 8'(mq.size())};
      3'd2, 3'd3: return (mq.size() == 0) ? 32'd0 : mq[0];
      3'd4: return mReq;
      3'd5: return 32'd0;
      3'd6: return mMask;
      default: return mReq & mMask;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R6";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic step(input bit vld, input logic [23:0] l, input logic [23:0] r,
                      input bit we, input bit re, input logic [2:0] a, input logic [31:0] wd);
    int used, mode, wl, lvl, n;
    bit sw, sg, clr, frz, pop, ovf, und;
    logic [31:0] exp, hwv, clrv, setv;
    logic [23:0] lv, rv;
    sampleValid = vld; sampleLeft = l; sampleRight = r;
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = wd;
    #1;
    exp = mRead(a);
    check(regRdData === exp, tagFor(a), regRdData, exp);
    used = mq.size();
    lvl = int'(mCfg[15:8]);
    check(trigReq === (used > lvl), "R7", {31'd0, trigReq}, {31'd0, used > lvl});
    check(irq === ((mReq & mMask) != 0), "R12", {31'd0, irq}, {31'd0, (mReq & mMask) != 0});
    lastRd = regRdData;
    mode = int'(mCfg[1:0]); sw = mCfg[2]; wl = int'(mCfg[5:4]); sg = mCfg[6];
    clr = mCfg[16]; frz = mCfg[17];
    pop = re && a == 3'd2 && !clr;
    und = pop && used == 0;
    ovf = 0;
    if (pop && used > 0) begin void'(mq.pop_front()); mRd = (mRd + 1) % 256; end
    if (vld && mode != 0 && !frz && !clr) begin
      n = (mode == 3) ? 2 : 1;
      if (used + n <= 255) begin
        lv = sw ? r : l; rv = sw ? l : r;
        if (mode == 1) mq.push_back(mExt(lv, wl, sg));
        else if (mode == 2) mq.push_back(mExt(rv, wl, sg));
        else begin mq.push_back(mExt(lv, wl, sg)); mq.push_back(mExt(rv, wl, sg)); end
        mWr = (mWr + n) % 256;
      end else ovf = 1;
    end
    if (clr) begin mq.delete(); mRd = 0; mWr = 0; end
    hwv = 0;
    hwv[16] = used > lvl; hwv[18] = used != 0; hwv[21] = ovf; hwv[22] = und;
    clrv = (we && a == 3'd4) ? (wd & VM) : 32'd0;
    setv = (we && a == 3'd5) ? (wd & VM) : 32'd0;
    mReq = (mReq & ~clrv) | hwv | setv;
    if (we && a == 3'd6) mMask = wd & VM;
    if (we && a == 3'd0) mCfg = wd;
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 3'd1, 0);
  endtask
  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    step(0, 0, 0, 1, 0, a, d);
  endtask
  task automatic rreg(input logic [2:0] a);
    step(0, 0, 0, 0, 1, a, 0);
  endtask
  function automatic logic [31:0] cfgw(input int mode, input bit sw, input int wl, input bit sg,
                                       input int lvl, input bit clr, input bit frz);
    return 32'(mode) | (32'(sw) << 2) | (32'(wl) << 4) | (32'(sg) << 6) |
           (32'(lvl) << 8) | (32'(clr) << 16) | (32'(frz) << 17);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rreg(3'd1); check(lastRd == 0, "R1", lastRd, 0);
    rreg(3'd4); check(lastRd == 0, "R1", lastRd, 0);
    check(trigReq == 0 && irq == 0, "R1", {30'd0, trigReq, irq}, 0);
    wreg(3'd6, VM);
    // R2 disabled mode writes nothing
    step(1, 24'h1, 24'h2, 0, 0, 3'd1, 0);
    rreg(3'd1); check(lastRd == 0, "R2", lastRd, 0);
    // R4 sign fill, 16 bit, left only
    wreg(3'd0, cfgw(1, 0, 0, 1, 200, 0, 0));
    step(1, 24'h7F8001, 24'h000555, 0, 0, 3'd1, 0);
    rreg(3'd3); check(lastRd == 32'hFFFF8001, "R4", lastRd, 32'hFFFF8001);
    // R4 zero fill 18 bit, right only with swap -> left input stored
    wreg(3'd0, cfgw(2, 1, 1, 0, 200, 0, 0));
    step(1, 24'hFE0003, 24'h000777, 0, 0, 3'd1, 0);
    wreg(3'd0, cfgw(2, 0, 2, 1, 200, 0, 0));
    step(1, 24'h000001, 24'h0F8000, 0, 0, 3'd1, 0);
    rreg(3'd2); check(lastRd == 32'hFFFF8001, "R5", lastRd, 32'hFFFF8001);
    rreg(3'd3); check(lastRd == 32'h00020003, "R2", lastRd, 32'h00020003);
    rreg(3'd3); check(lastRd == 32'h00020003, "R5", lastRd, 32'h00020003);
    rreg(3'd2); rreg(3'd2); check(lastRd == 32'hFFFF8000, "R4", lastRd, 32'hFFFF8000);
    // R5/R10 pop empty
    rreg(3'd1); keep = lastRd;
    rreg(3'd2); check(lastRd == 0, "R5", lastRd, 0);
    rreg(3'd1); check(lastRd == keep, "R5", lastRd, keep);
    rreg(3'd4); check(lastRd[22] == 1, "R10", {31'd0, lastRd[22]}, 1);
    wreg(3'd4, VM);
    // R3 stereo order, 24 bit
    wreg(3'd0, cfgw(3, 0, 3, 0, 2, 0, 0));
    step(1, 24'h000123, 24'h000456, 0, 0, 3'd1, 0);
    rreg(3'd2); check(lastRd == 32'h123, "R3", lastRd, 32'h123);
    rreg(3'd2); check(lastRd == 32'h456, "R3", lastRd, 32'h456);
    // R7 trigger strictly greater
    for (int i = 0; i < 2; i++) step(1, 24'(i), 24'(i + 9), 0, 0, 3'd1, 0);
    idle(2);
    // R11 set wins: clear trig/nempty while conditions hold
    wreg(3'd4, VM);
    rreg(3'd4); check(lastRd[18] == 1 && lastRd[16] == 1, "R11", lastRd, VM);
    wreg(3'd5, 32'h0020_0000);
    rreg(3'd4); check(lastRd[21] == 1, "R11", lastRd, 32'h0020_0000);
    // R8 held clear
    wreg(3'd0, cfgw(3, 0, 3, 0, 2, 1, 0));
    for (int i = 0; i < 4; i++) step(1, 24'h5, 24'h6, 0, 1, 3'd2, 0);
    rreg(3'd1); check(lastRd == 0, "R8", lastRd, 0);
    wreg(3'd4, VM);
    // R3/R6/R10 fill to capacity
    wreg(3'd0, cfgw(3, 0, 3, 0, 253, 0, 0));
    for (int i = 0; i < 128; i++) step(1, 24'(2 * i), 24'(2 * i + 1), 0, 0, 3'd1, 0);
    rreg(3'd1); check(lastRd[7:0] == 8'd254, "R3", lastRd, 32'd254);
    rreg(3'd4); check(lastRd[21] == 1, "R10", lastRd, 32'h0020_0000);
    wreg(3'd0, cfgw(1, 0, 3, 0, 254, 0, 0));
    step(1, 24'hAA, 0, 0, 0, 3'd1, 0);
    step(1, 24'hBB, 0, 0, 0, 3'd1, 0);
    rreg(3'd1); check(lastRd == 32'h00FF00FF, "R6", lastRd, 32'h00FF00FF);
    // R9 freeze
    rreg(3'd2); wreg(3'd4, VM);
    wreg(3'd0, cfgw(1, 0, 3, 0, 254, 0, 1));
    rreg(3'd1); keep = lastRd;
    for (int i = 0; i < 5; i++) step(1, 24'h1, 24'h2, 0, 0, 3'd1, 0);
    rreg(3'd1); check(lastRd == keep, "R9", lastRd, keep);
    rreg(3'd4); check(lastRd[21] == 0, "R9", lastRd, 0);
    wreg(3'd0, cfgw(1, 0, 3, 0, 254, 1, 0));
    // mixed random traffic with pop/write and set/clear collisions
    wreg(3'd0, cfgw(3, 0, 0, 1, 20, 0, 0));
    for (int i = 0; i < 6000; i++) begin
      int c;
      c = $urandom_range(0, 99);
      if (c < 3)
        step(1, 24'($urandom), 24'($urandom), 1, 0, 3'd0,
             cfgw($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
                  $urandom_range(0, 60), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)));
      else if (c < 8) step(1, 24'($urandom), 24'($urandom), 1, 0, 3'd4, $urandom);
      else if (c < 10) step(1, 24'($urandom), 24'($urandom), 1, 0, 3'd5, $urandom & 32'h0060_0000);
      else if (c < 12) step(0, 0, 0, 1, 0, 3'd6, $urandom);
      else if (c < 55) step(1'($urandom), 24'($urandom), 24'($urandom), 0, 1, 3'($urandom_range(1, 7)), 0);
      else step(1'($urandom), 24'($urandom), 24'($urandom), 0, 1, 3'd2, 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule